// File: doc/BRIEF.md
# PWM Frequency and Duty Meter

This block measures a pulse-width-modulated pilot signal and reports its frequency in hertz and its duty cycle in whole percent. A prescaler derives a tick of about 1 MHz from the system clock, and a free-running tick counter wraps at a reload value that software supplies. The raw pin is synchronized and deglitched. A three-step capture sequence then takes three counter stamps: the first rising edge, the falling edge that follows, and the next rising edge.

From those stamps the block forms the period and the high time with differences that survive one counter wrap. It checks them for sanity and divides them with two iterative dividers. The frequency, the duty and a valid flag are loaded into one register set in a single clock, with a one-cycle update strobe, so a reader never sees a mix of old and new values. If no good period arrives within a staleness window (200 ms by default), all three outputs drop to zero.

Top module: `pwm_meter`

## Requirements
- R1: The tick divisor is CLK_HZ/TICK_HZ − 1, or 0 when CLK_HZ is not above TICK_HZ, and is limited to 65535. One tick occurs every divisor+1 clocks, and the tick rate is CLK_HZ/(divisor+1).
- R2: On each tick the counter advances by one. When it is at or above `reload`, the next tick takes it to 0.
- R3: The pilot passes through two synchronizing flops. A level change is accepted only after it has held for FILT_LEN consecutive clocks (default 2), so a one-clock pulse produces no edge.
- R4: Capture runs in the order rise, fall, rise. The second rise ends the sequence and is not reused, so a continuous waveform yields one result per two periods.
- R5: A tick difference is now−prev when now ≥ prev, and (reload−prev+1)+now otherwise. Period and high time come out correct across one counter wrap.
- R6: A sequence whose period difference is 0, or whose high time exceeds its period, or any sequence when the tick rate is 0, gives an update with valid=0. Frequency and duty are left unchanged.
- R7: Frequency is the tick rate divided by the period in ticks, using integer division.
- R8: The high-time duty is (high·100 + period/2)/period, limited to 100. The reported duty never exceeds 100.
- R9: With INVERT=1 the reported duty is 100 minus the high-time duty. With INVERT=0 it is the high-time duty.
- R10: If more than the staleness window passes without an accepted result, frequency, duty and valid are set to 0, with one update strobe.
- R11: Frequency, duty and valid change only in a cycle where `meas_upd` is high. Each accepted result gives exactly one strobe.
- R12: Reset clears the outputs and the strobe, returns capture to waiting for the first rise, and restarts the staleness timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pilot_in | input | 1 | Raw pilot PWM pin |
| reload | input | CNT_W | Highest value of the tick counter before it wraps |
| freq_hz | output | 32 | Measured frequency in hertz |
| duty_pct | output | 7 | Measured duty in percent, 0 to 100 |
| meas_valid | output | 1 | The last sequence was accepted and is not stale |
| meas_upd | output | 1 | One-cycle strobe when the output triple is loaded |

## Verification
Some properties are checked on every cycle by the assertions. Ticks are never back to back when the divisor is non-zero, and the counter never exceeds `reload` after a tick. The duty stays within 100 while valid, the outputs change only under the update strobe, and the outputs stay zero once the staleness counter passes its limit.

Other behaviour only the bench scenarios can show. These are the arithmetic of frequency and rounded duty over a sweep of periods and high times, the inverted and plain duty, and correct results across counter wraps. The bench also covers the two reject cases, glitch rejection, the one-result-per-two-periods ordering and reset mid-run.

// File: rtl/pm_pkg.sv
package pm_pkg;
    typedef enum logic [1:0] {
        CAP_RISE1 = 2'd0,
        CAP_FALL  = 2'd1,
        CAP_RISE2 = 2'd2
    } cap_state_e;
endpackage

// File: rtl/pm_edge_filter.sv
module pm_edge_filter #(
    parameter int LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int CW = $clog2(LEN + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          lvl;
        logic [CW-1:0] cnt;
        logic          rise;
        logic          fall;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], pin};
        st_d.rise = 1'b0;
        st_d.fall = 1'b0;
        if (st_q.sync[1] != st_q.lvl) begin
            if (st_q.cnt == CW'(LEN - 1)) begin
                st_d.lvl  = st_q.sync[1];
                st_d.cnt  = '0;
                st_d.rise = st_q.sync[1];
                st_d.fall = ~st_q.sync[1];
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rise = st_q.rise;
    assign fall = st_q.fall;
endmodule

// File: rtl/pm_divider.sv
module pm_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic         done
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [W:0]    rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  den;
        logic          done;
    } div_st_t;

    div_st_t  st_d, st_q;
    logic [W:0] shifted;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        shifted   = {st_q.rem[W-1:0], st_q.quo[W-1]};
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.cnt  = CW'(W);
                st_d.rem  = '0;
                st_d.quo  = dividend;
                st_d.den  = divisor;
            end
        end else begin
            if (shifted >= {1'b0, st_q.den}) begin
                st_d.rem = shifted - {1'b0, st_q.den};
                st_d.quo = {st_q.quo[W-2:0], 1'b1};
            end else begin
                st_d.rem = shifted;
                st_d.quo = {st_q.quo[W-2:0], 1'b0};
            end
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CW'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign quotient = st_q.quo;
    assign done     = st_q.done;
endmodule

// File: rtl/pwm_meter.sv
module pwm_meter
    import pm_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int TICK_HZ  = 1_000_000,
    parameter int CNT_W    = 16,
    parameter int FILT_LEN = 2,
    parameter int STALE_US = 200_000,
    parameter bit INVERT   = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pilot_in,
    input  logic [CNT_W-1:0] reload,
    output logic [31:0]      freq_hz,
    output logic [6:0]       duty_pct,
    output logic             meas_valid,
    output logic             meas_upd
);
    localparam int     PRESC_RAW  = (CLK_HZ > TICK_HZ) ? (CLK_HZ / TICK_HZ) - 1 : 0;
    localparam int     PRESC      = (PRESC_RAW > 65535) ? 65535 : PRESC_RAW;
    localparam int     TICK_RATE  = CLK_HZ / (PRESC + 1);
    localparam bit     NO_RATE    = (TICK_RATE == 0);
    localparam longint STALE_CLKS = (longint'(CLK_HZ) * longint'(STALE_US)) / 64'sd1_000_000;
    localparam int     STL_W      = $clog2(STALE_CLKS + 2);
    localparam int     DIV_W      = 32;
    localparam int     DW         = CNT_W + 1;
    localparam logic [STL_W-1:0] STALE_LIM = STL_W'(STALE_CLKS);
    localparam logic [15:0]      PRESC_V   = 16'(PRESC);

    typedef struct packed {
        logic [15:0]      pre;
        logic [CNT_W-1:0] cnt;
        cap_state_e       cap;
        logic [CNT_W-1:0] r1;
        logic [CNT_W-1:0] fe;
        logic [STL_W-1:0] stale;
        logic [31:0]      freq;
        logic [6:0]       duty;
        logic             valid;
        logic             upd;
    } meter_st_t;

    meter_st_t st_d, st_q;

    // Difference of two counter stamps that survives one wrap.
    function automatic logic [DW-1:0] tick_span(input logic [CNT_W-1:0] now,
                                                input logic [CNT_W-1:0] prev,
                                                input logic [CNT_W-1:0] top);
        if (now >= prev) return {1'b0, now} - {1'b0, prev};
        return ({1'b0, top} - {1'b0, prev}) + DW'(1) + {1'b0, now};
    endfunction

    logic             tick;
    logic             edge_rise, edge_fall;
    logic [DW-1:0]    span_per, span_hi;
    logic             reject;
    logic             div_go;
    logic [DIV_W-1:0] freq_q, duty_q;
    logic             freq_done, duty_done;
    logic [6:0]       duty_hi, duty_out;

    pm_edge_filter #(.LEN(FILT_LEN)) u_filt (
        .clk  (clk),
        .rst  (rst),
        .pin  (pilot_in),
        .rise (edge_rise),
        .fall (edge_fall)
    );

    assign tick     = (st_q.pre == PRESC_V);
    assign span_per = tick_span(st_q.cnt, st_q.r1, reload);
    assign span_hi  = tick_span(st_q.fe, st_q.r1, reload);
    assign reject   = (span_per == '0) || (span_hi > span_per) || NO_RATE;

    pm_divider #(.W(DIV_W)) u_div_freq (
        .clk      (clk),
        .rst      (rst),
        .start    (div_go),
        .dividend (DIV_W'(TICK_RATE)),
        .divisor  (DIV_W'(span_per)),
        .quotient (freq_q),
        .done     (freq_done)
    );

    pm_divider #(.W(DIV_W)) u_div_duty (
        .clk      (clk),
        .rst      (rst),
        .start    (div_go),
        .dividend (DIV_W'(span_hi) * DIV_W'(100) + DIV_W'(span_per >> 1)),
        .divisor  (DIV_W'(span_per)),
        .quotient (duty_q),
        .done     (duty_done)
    );

    assign duty_hi = (duty_q > DIV_W'(100)) ? 7'd100 : duty_q[6:0];

    generate
        if (INVERT) begin : g_inv
            assign duty_out = 7'd100 - duty_hi;
        end else begin : g_plain
            assign duty_out = duty_hi;
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        div_go   = 1'b0;
        st_d.pre = tick ? '0 : st_q.pre + 16'd1;
        if (tick) begin
            st_d.cnt = (st_q.cnt >= reload) ? '0 : st_q.cnt + 1'b1;
        end
        case (st_q.cap)
            CAP_RISE1: if (edge_rise) begin
                st_d.r1  = st_q.cnt;
                st_d.cap = CAP_FALL;
            end
            CAP_FALL: if (edge_fall) begin
                st_d.fe  = st_q.cnt;
                st_d.cap = CAP_RISE2;
            end
            CAP_RISE2: if (edge_rise) begin
                st_d.cap = CAP_RISE1;
                if (reject) begin
                    st_d.valid = 1'b0;
                    st_d.upd   = 1'b1;
                end else begin
                    div_go = 1'b1;
                end
            end
            default: st_d.cap = CAP_RISE1;
        endcase
        if (st_q.stale <= STALE_LIM) begin
            st_d.stale = st_q.stale + 1'b1;
        end
        if (st_q.stale == STALE_LIM) begin
            st_d.freq  = '0;
            st_d.duty  = '0;
            st_d.valid = 1'b0;
            st_d.upd   = 1'b1;
        end
        if (freq_done && duty_done) begin
            st_d.freq  = freq_q;
            st_d.duty  = duty_out;
            st_d.valid = 1'b1;
            st_d.upd   = 1'b1;
            st_d.stale = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign freq_hz    = st_q.freq;
    assign duty_pct   = st_q.duty;
    assign meas_valid = st_q.valid;
    assign meas_upd   = st_q.upd;
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
    parameter int     CNT_W     = 16,
    parameter int     STL_W     = 8,
    parameter longint STALE_LIM = 100,
    parameter int     PRESC     = 1
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic [CNT_W-1:0] reload,
    input logic [CNT_W-1:0] cnt,
    input logic [STL_W-1:0] stale,
    input logic [31:0]      freq,
    input logic [6:0]       duty,
    input logic             valid,
    input logic             upd
);
    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        (PRESC > 0 && tick) |=> !tick); // R1

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt <= $past(reload))); // R2

    AST_DUTY_RANGE: assert property (@(posedge clk) disable iff (rst)
        valid |-> (duty <= 7'd100)); // R8

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !upd |-> ($stable(freq) && $stable(duty) && $stable(valid))); // R11

    AST_STALE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (stale > STL_W'(STALE_LIM)) |-> (!valid && freq == '0 && duty == '0)); // R10
endmodule

bind pwm_meter pm_checker #(
    .CNT_W     (CNT_W),
    .STL_W     (STL_W),
    .STALE_LIM (STALE_CLKS),
    .PRESC     (PRESC)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .reload (reload),
    .cnt    (st_q.cnt),
    .stale  (st_q.stale),
    .freq   (freq_hz),
    .duty   (duty_pct),
    .valid  (meas_valid),
    .upd    (meas_upd)
);

// File: tb/tb_pwm_meter.sv
module tb_pwm_meter;
    localparam int CLK_HZ   = 8_000_000;
    localparam int TICK_HZ  = 1_000_000;
    localparam int CNT_W    = 8;
    localparam int STALE_US = 3000;
    localparam int TPC      = 8;          // clocks per tick
    localparam int RATE     = 1_000_000;  // resulting tick rate
    localparam int STALE_C  = 24000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin = 1'b0;
    logic [CNT_W-1:0] reload = 8'd255;
    logic [31:0] fr [2];
    logic [6:0]  du [2];
    logic        va [2];
    logic        up [2];

    always #2.5 clk = ~clk;

    pwm_meter #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .CNT_W(CNT_W), .FILT_LEN(2),
                .STALE_US(STALE_US), .INVERT(1'b1)) dut (
        .clk(clk), .rst(rst), .pilot_in(pin), .reload(reload),
        .freq_hz(fr[0]), .duty_pct(du[0]), .meas_valid(va[0]), .meas_upd(up[0]));

    pwm_meter #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .CNT_W(CNT_W), .FILT_LEN(2),
                .STALE_US(STALE_US), .INVERT(1'b0)) dut_plain (
        .clk(clk), .rst(rst), .pilot_in(pin), .reload(reload),
        .freq_hz(fr[1]), .duty_pct(du[1]), .meas_valid(va[1]), .meas_upd(up[1]));

    int errs = 0;
    int checks = 0;
    int nupd [2] = '{0, 0};
    int incoh [2] = '{0, 0};
    logic [31:0] pf [2];
    logic [6:0]  pd [2];
    logic        pv [2];
    logic        rst_d = 1'b1;
    longint exp_f = 0;
    longint exp_dh = 0;

    // Output monitor: counts strobes and any change without a strobe (R11)
    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (!rst && !rst_d) begin
                if (up[i]) nupd[i]++;
                else if (fr[i] != pf[i] || du[i] != pd[i] || va[i] != pv[i]) incoh[i]++;
            end
            pf[i] = fr[i];
            pd[i] = du[i];
            pv[i] = va[i];
        end
        rst_d = rst;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        clocks(n * TPC);
    endtask

    // Check both instances: valid, freq, duty, and strobe count delta
    task automatic verify(input string req, input longint v, input longint f, input longint dh,
                          input int b0, input int b1, input int dn);
        chk({req, " count"}, nupd[0] - b0, dn);
        chk({req, " count plain"}, nupd[1] - b1, dn);
        for (int i = 0; i < 2; i++) begin
            chk({req, " valid"}, va[i], v);
            chk({req, " freq"}, fr[i], f);
            chk({req, " duty"}, du[i], (i == 0 && v != 0) ? 100 - dh : dh);
        end
    endtask

    // rise, H high, P-H low, rise, H high, fall
    task automatic wave(input int p, input int h);
        pin = 1'b1; ticks(h);
        pin = 1'b0; ticks(p - h);
        pin = 1'b1; ticks(h);
        pin = 1'b0; clocks(80);
    endtask

    task automatic measure(input string req, input int p, input int h);
        int b0, b1;
        b0 = nupd[0]; b1 = nupd[1];
        wave(p, h);
        exp_f  = RATE / p;
        exp_dh = (h * 100 + p / 2) / p;
        if (exp_dh > 100) exp_dh = 100;
        verify(req, 1, exp_f, exp_dh, b0, b1, 1);
    endtask

    task automatic measure_reject(input string req, input int p, input int h);
        int b0, b1;
        longint keep_dh;
        b0 = nupd[0]; b1 = nupd[1];
        wave(p, h);
        // R6: valid low, freq and duty unchanged; inverted duty kept as loaded
        chk({req, " count"}, nupd[0] - b0, 1);
        chk({req, " count plain"}, nupd[1] - b1, 1);
        for (int i = 0; i < 2; i++) begin
            keep_dh = (i == 0) ? 100 - exp_dh : exp_dh;
            chk({req, " valid"}, va[i], 0);
            chk({req, " freq kept"}, fr[i], exp_f);
            chk({req, " duty kept"}, du[i], keep_dh);
        end
    endtask

    initial begin
        clocks(5);
        // R12: outputs clear under reset
        for (int i = 0; i < 2; i++) begin
            chk("R12 reset freq", fr[i], 0);
            chk("R12 reset duty", du[i], 0);
            chk("R12 reset valid", va[i], 0);
            chk("R12 reset upd", up[i], 0);
        end
        rst = 1'b0;
        clocks(20);

        // R1 R7 R8 R9 sweep, with natural wraps of the 0..255 counter (R5)
        for (int p = 5; p <= 24; p++) begin
            for (int h = 1; h < p; h++) begin
                measure("R7 R8 R9 sweep", p, h);
            end
        end

        // R5: wraps of a 0..99 counter
        reload = 8'd99;
        for (int k = 0; k < 4; k++) measure("R5 wrap", 60, 30);

        // R2/R6: a period equal to the counter modulus gives a zero difference
        measure_reject("R6 zero period R2", 100, 30);
        // R6: high time longer than the wrapped period
        measure_reject("R6 high over period", 110, 90);
        // R2: with a larger reload the same period is good
        reload = 8'd255;
        measure("R2 reload 255", 100, 30);

        // R3: one-clock glitches are not edges
        begin
            int b0, b1;
            b0 = nupd[0]; b1 = nupd[1];
            pin = 1'b1; ticks(3);
            pin = 1'b0; clocks(1);
            pin = 1'b1; clocks(5 * TPC - 1);
            pin = 1'b0; ticks(4);
            pin = 1'b1; clocks(1);
            pin = 1'b0; clocks(8 * TPC - 1);
            pin = 1'b1; ticks(8);
            pin = 1'b0; clocks(80);
            exp_f = RATE / 20; exp_dh = (8 * 100 + 10) / 20;
            verify("R3 glitch", 1, exp_f, exp_dh, b0, b1, 1);
        end

        // R4: six back-to-back periods yield three results
        begin
            int b0, b1;
            b0 = nupd[0]; b1 = nupd[1];
            for (int k = 0; k < 6; k++) begin
                pin = 1'b1; ticks(4);
                pin = 1'b0; ticks(6);
            end
            clocks(80);
            exp_f = RATE / 10; exp_dh = 40;
            verify("R4 non-overlap", 1, exp_f, exp_dh, b0, b1, 3);
        end

        // R12: reset mid-run clears outputs
        rst = 1'b1;
        clocks(3);
        for (int i = 0; i < 2; i++) begin
            chk("R12 mid reset freq", fr[i], 0);
            chk("R12 mid reset valid", va[i], 0);
            chk("R12 mid reset upd", up[i], 0);
        end
        rst = 1'b0;
        clocks(5);
        measure("R12 after reset", 16, 4);

        // R10: staleness zeroes the triple with one strobe
        begin
            int b0, b1;
            b0 = nupd[0]; b1 = nupd[1];
            clocks(STALE_C + 200);
            verify("R10 stale", 0, 0, 0, b0, b1, 1);
        end

        // R11: no output change without a strobe
        chk("R11 coherent", incoh[0], 0);
        chk("R11 coherent plain", incoh[1], 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule